// File: doc/BRIEF.md
# Masked Control Register File

This block holds the internal 64-bit control registers of a processor core. A single read port and a single write port address the registers by a 6-bit index. Each index has its own write mask and access class: plain read/write, read-only, write-only, clear-on-write, or unmapped. Data is stored only in the bits the mask allows. An access that the class forbids raises a fault flag in the same cycle and changes nothing.

One register combines stored and live state. Its upper 32 bits are stored, and its lower 32 bits come from a free-running cycle counter. A speculation input suppresses every write without raising a fault. Writes to four translation-buffer invalidate indices produce one-cycle strobes for the buffers, which sit outside the block. Two exception registers collect flag bits from hardware set inputs, and any software write clears them.

Reads are combinational. A write takes effect at the next rising clock edge. Reset is synchronous and active high, and it loads the defined start values.

Top module: `crf_regfile`

## Requirements
- R1: After reset, index 9 (memory control) reads 0x6, index 8 (base address) reads parameter BASE_RESET, index 7 (scratch) reads parameter CPU_ID, and every other stored register reads 0.
- R2: Indices 0–10 (scratch 0–7, base address, memory control, performance counter) store all 64 written bits. A read returns the data in the same cycle, and a write is visible from the next clock edge.
- R3: Writes keep only the bits under each register's mask: 12/13 0xf; 14 0x1f; 15 0x18; 16 0x7fff0; 17 0xffffff0300; 18/19 0xffffffffc0000000; 20 0x1ffb; 21/22 0x3f; 23 0x7f0; 24 0xfe00000000000000.
- R4: A write to index 11 (exception address) stores the data with bit 1 forced to zero.
- R5: Indices 26 (exception summary) and 27 (exception mask) OR in the bits of exc_sum_set and exc_mask_set every cycle. Any write clears the register to zero whatever the data, and a write in the same cycle as a set wins.
- R6: A write to a read-only index (28–32) raises wr_fault in that cycle and leaves the register reading 0 without rd_fault.
- R7: A read of a write-only index (33–41) raises rd_fault and returns 0. A write to such an index is accepted without fault.
- R8: Indices 42–63 are unmapped. A read raises rd_fault, and a write raises wr_fault.
- R9: A read of index 25 (cycle count) returns the stored upper 32 bits above a live 32-bit counter. The counter is 0 during reset and advances by one every clock.
- R10: While spec is high, writes change no register, raise no wr_fault and produce no strobe.
- R11: A non-speculative write to index 38, 39, 40 or 41 sets inval_pulse bit 0, 1, 2 or 3 respectively for exactly the one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spec | input | 1 | Speculation flag; suppresses writes |
| rd_en | input | 1 | Read request |
| rd_idx | input | 6 | Read index |
| rd_data | output | 64 | Read data, combinational |
| rd_fault | output | 1 | Read access violates class or index unmapped |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Write access violates class or index unmapped |
| exc_sum_set | input | 64 | Bits ORed into the exception summary register |
| exc_mask_set | input | 64 | Bits ORed into the exception mask register |
| inval_pulse | output | 4 | Invalidate strobes: data-all, data-process, instr-all, instr-process |

## Verification
A write to the wrong slot or with the wrong mask appears at the next read of either the target index or its neighbours, one cycle after the write edge. Stray bits in a masked register therefore show up on the first read-back. Strobe and fault errors are visible in the same cycle as the access or the cycle after it. Counter faults appear as a difference other than the elapsed cycles between two reads of the cycle register.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int DATA_W  = 64;
    localparam int IDX_W   = 6;
    localparam int CNT_W   = 32;
    localparam int N_STORE = 28;
    localparam int N_INV   = 4;

    // stored registers
    localparam logic [IDX_W-1:0] IX_SCR7    = 6'd7;
    localparam logic [IDX_W-1:0] IX_BASE    = 6'd8;
    localparam logic [IDX_W-1:0] IX_MEMCTL  = 6'd9;
    localparam logic [IDX_W-1:0] IX_PERF    = 6'd10;
    localparam logic [IDX_W-1:0] IX_EXCADR  = 6'd11;
    localparam logic [IDX_W-1:0] IX_TRAPREQ = 6'd12;
    localparam logic [IDX_W-1:0] IX_TRAPEN  = 6'd13;
    localparam logic [IDX_W-1:0] IX_PRIO    = 6'd14;
    localparam logic [IDX_W-1:0] IX_CURMODE = 6'd15;
    localparam logic [IDX_W-1:0] IX_SWINT   = 6'd16;
    localparam logic [IDX_W-1:0] IX_CTLSTAT = 6'd17;
    localparam logic [IDX_W-1:0] IX_IPTBASE = 6'd18;
    localparam logic [IDX_W-1:0] IX_DPTBASE = 6'd19;
    localparam logic [IDX_W-1:0] IX_CTEST   = 6'd20;
    localparam logic [IDX_W-1:0] IX_DCMODE  = 6'd21;
    localparam logic [IDX_W-1:0] IX_MAFMODE = 6'd22;
    localparam logic [IDX_W-1:0] IX_IASID   = 6'd23;
    localparam logic [IDX_W-1:0] IX_DASID   = 6'd24;
    localparam logic [IDX_W-1:0] IX_CYCLE   = 6'd25;
    localparam logic [IDX_W-1:0] IX_EXCSUM  = 6'd26;
    localparam logic [IDX_W-1:0] IX_EXCMSK  = 6'd27;
    // read-only range
    localparam logic [IDX_W-1:0] IX_RO_LO   = 6'd28;
    localparam logic [IDX_W-1:0] IX_RO_HI   = 6'd32;
    // write-only range, invalidate strobes at the top of it
    localparam logic [IDX_W-1:0] IX_WO_LO   = 6'd33;
    localparam logic [IDX_W-1:0] IX_INV_LO  = 6'd38;
    localparam logic [IDX_W-1:0] IX_WO_HI   = 6'd41;

    typedef enum logic [2:0] {
        ACC_RW,
        ACC_COW,
        ACC_RO,
        ACC_WO,
        ACC_NONE
    } acc_e;

    typedef struct packed {
        acc_e              kind;
        logic [DATA_W-1:0] mask;
        logic              stored;
    } reg_info_t;

    function automatic logic [DATA_W-1:0] wr_mask(input logic [IDX_W-1:0] idx);
        logic [DATA_W-1:0] m;
        case (idx)
            IX_EXCADR:             m = ~64'h2;
            IX_TRAPREQ, IX_TRAPEN: m = 64'hf;
            IX_PRIO:               m = 64'h1f;
            IX_CURMODE:            m = 64'h18;
            IX_SWINT:              m = 64'h7fff0;
            IX_CTLSTAT:            m = 64'hff_ffff_0300;
            IX_IPTBASE, IX_DPTBASE: m = 64'hffff_ffff_c000_0000;
            IX_CTEST:              m = 64'h1ffb;
            IX_DCMODE, IX_MAFMODE: m = 64'h3f;
            IX_IASID:              m = 64'h7f0;
            IX_DASID:              m = 64'hfe00_0000_0000_0000;
            IX_EXCSUM, IX_EXCMSK:  m = '0;
            default:               m = '1;
        endcase
        return m;
    endfunction

    function automatic reg_info_t get_info(input logic [IDX_W-1:0] idx);
        reg_info_t r;
        r.mask   = wr_mask(idx);
        r.stored = (idx < IDX_W'(N_STORE));
        if (idx == IX_EXCSUM || idx == IX_EXCMSK)
            r.kind = ACC_COW;
        else if (idx < IX_RO_LO)
            r.kind = ACC_RW;
        else if (idx <= IX_RO_HI)
            r.kind = ACC_RO;
        else if (idx <= IX_WO_HI)
            r.kind = ACC_WO;
        else
            r.kind = ACC_NONE;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] reset_val(
        input int                slot,
        input logic [DATA_W-1:0] base_rst,
        input logic [DATA_W-1:0] cpu_id
    );
        if (slot == int'(IX_MEMCTL)) return 64'h6;
        if (slot == int'(IX_BASE))   return base_rst;
        if (slot == int'(IX_SCR7))   return cpu_id;
        return '0;
    endfunction

endpackage

// File: rtl/crf_decode.sv
module crf_decode
    import crf_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output reg_info_t        info
);
    always_comb info = get_info(idx);
endmodule

// File: rtl/crf_cycle.sv
module crf_cycle
    import crf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end
endmodule

// File: rtl/crf_strobe.sv
module crf_strobe
    import crf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [IDX_W-1:0] idx,
    output logic [N_INV-1:0] pulse
);
    logic [N_INV-1:0] next_pulse;

    always_comb begin
        next_pulse = '0;
        for (int k = 0; k < N_INV; k++) begin
            if (accept && idx == IX_INV_LO + IDX_W'(k))
                next_pulse[k] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pulse <= '0;
        else     pulse <= next_pulse;
    end
endmodule

// File: rtl/crf_store.sv
module crf_store
    import crf_pkg::*;
#(
    parameter logic [DATA_W-1:0] BASE_RESET = 64'h0,
    parameter logic [DATA_W-1:0] CPU_ID     = 64'h0
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [IDX_W-1:0]               widx,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [DATA_W-1:0]              sum_set,
    input  logic [DATA_W-1:0]              msk_set,
    output logic [N_STORE-1:0][DATA_W-1:0] q
);
    for (genvar s = 0; s < N_STORE; s++) begin : g_slot
        localparam logic [DATA_W-1:0] RST_V = reset_val(s, BASE_RESET, CPU_ID);
        logic hit;
        assign hit = we && (widx == IDX_W'(s));

        if (s == int'(IX_EXCSUM) || s == int'(IX_EXCMSK)) begin : g_sticky
            logic [DATA_W-1:0] set_bits;
            assign set_bits = (s == int'(IX_EXCSUM)) ? sum_set : msk_set;
            always_ff @(posedge clk) begin
                if (rst)      q[s] <= RST_V;
                else if (hit) q[s] <= wdata;
                else          q[s] <= q[s] | set_bits;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)      q[s] <= RST_V;
                else if (hit) q[s] <= wdata;
            end
        end
    end
endmodule

// File: rtl/crf_regfile.sv
module crf_regfile
    import crf_pkg::*;
#(
    parameter logic [63:0] BASE_RESET = 64'h0000_0000_0000_4000,
    parameter logic [63:0] CPU_ID     = 64'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        spec,
    input  logic        rd_en,
    input  logic [5:0]  rd_idx,
    output logic [63:0] rd_data,
    output logic        rd_fault,
    input  logic        wr_en,
    input  logic [5:0]  wr_idx,
    input  logic [63:0] wr_data,
    output logic        wr_fault,
    input  logic [63:0] exc_sum_set,
    input  logic [63:0] exc_mask_set,
    output logic [3:0]  inval_pulse
);
    reg_info_t rinfo, winfo;
    logic [N_STORE-1:0][DATA_W-1:0] regs;
    logic [CNT_W-1:0] cycles;
    logic wr_live, wr_ok, st_we;
    logic [DATA_W-1:0] st_data, stored_rd;

    crf_decode u_rdec (.idx(rd_idx), .info(rinfo));
    crf_decode u_wdec (.idx(wr_idx), .info(winfo));

    crf_cycle u_cyc (.clk(clk), .rst(rst), .count(cycles));

    assign wr_live  = wr_en && !spec;
    assign wr_ok    = wr_live && (winfo.kind inside {ACC_RW, ACC_COW, ACC_WO});
    assign wr_fault = wr_live && (winfo.kind inside {ACC_RO, ACC_NONE});
    assign st_we    = wr_ok && winfo.stored;
    assign st_data  = wr_data & winfo.mask;

    crf_store #(.BASE_RESET(BASE_RESET), .CPU_ID(CPU_ID)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (st_we),
        .widx   (wr_idx),
        .wdata  (st_data),
        .sum_set(exc_sum_set),
        .msk_set(exc_mask_set),
        .q      (regs)
    );

    crf_strobe u_strobe (
        .clk   (clk),
        .rst   (rst),
        .accept(wr_ok),
        .idx   (wr_idx),
        .pulse (inval_pulse)
    );

    always_comb begin
        stored_rd = '0;
        if (rinfo.stored)
            stored_rd = regs[rd_idx[$clog2(N_STORE)-1:0]];
    end

    assign rd_fault = rd_en && (rinfo.kind inside {ACC_WO, ACC_NONE});

    always_comb begin
        rd_data = '0;
        if (rd_en && !rd_fault && rinfo.stored) begin
            if (rd_idx == IX_CYCLE)
                rd_data = {stored_rd[DATA_W-1:CNT_W], cycles};
            else
                rd_data = stored_rd;
        end
    end
endmodule

// File: rtl/crf_checker.sv
module crf_checker
    import crf_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        spec,
    input logic        rd_en,
    input logic [5:0]  rd_idx,
    input logic [63:0] rd_data,
    input logic        rd_fault,
    input logic        wr_en,
    input logic [5:0]  wr_idx,
    input logic        wr_fault,
    input logic [3:0]  inval_pulse
);
    AST_SPEC_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        spec |-> !wr_fault); // R10

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(inval_pulse)); // R11

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (inval_pulse != 4'b0) |-> $past(wr_en && !spec && wr_idx >= IX_INV_LO && wr_idx <= IX_WO_HI)); // R11

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_fault |-> (rd_data == 64'h0)); // R7

    AST_EXCADR_BIT1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_idx == IX_EXCADR) |-> !rd_data[1]); // R4

    AST_PRIO_MASK: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_idx == IX_PRIO) |-> (rd_data[63:5] == '0)); // R3

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_idx == IX_CYCLE && $past(!rst && rd_en && rd_idx == IX_CYCLE))
        |-> (rd_data[31:0] == $past(rd_data[31:0]) + 32'd1)); // R9

    AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !spec && wr_idx > IX_WO_HI) |-> wr_fault); // R8
endmodule

bind crf_regfile crf_checker u_crf_checker (
    .clk        (clk),
    .rst        (rst),
    .spec       (spec),
    .rd_en      (rd_en),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .rd_fault   (rd_fault),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_fault   (wr_fault),
    .inval_pulse(inval_pulse)
);

// File: tb/test_crf_regfile.sv
`timescale 1ns/1ps
module test_crf_regfile;
    localparam logic [63:0] T_BASE = 64'h0000_0000_0012_0000;
    localparam logic [63:0] T_CPU  = 64'h0000_0000_0000_0003;

    logic        clk = 1'b0;
    logic        rst, spec, rd_en, wr_en;
    logic [5:0]  rd_idx, wr_idx;
    logic [63:0] wr_data, rd_data, exc_sum_set, exc_mask_set;
    logic        rd_fault, wr_fault;
    logic [3:0]  inval_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    crf_regfile #(.BASE_RESET(T_BASE), .CPU_ID(T_CPU)) i_crf_regfile (
        .clk(clk), .rst(rst), .spec(spec),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_fault(rd_fault),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_fault(wr_fault),
        .exc_sum_set(exc_sum_set), .exc_mask_set(exc_mask_set),
        .inval_pulse(inval_pulse)
    );

    // {req, idx, write data, expected read}
    localparam int NV = 18;
    localparam logic [137:0] VEC [NV] = '{
        {4'd2, 6'd3,  64'hdead_beef_0123_4567, 64'hdead_beef_0123_4567}, // R2
        {4'd2, 6'd10, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff}, // R2
        {4'd2, 6'd8,  64'h0000_0000_0010_0000, 64'h0000_0000_0010_0000}, // R2
        {4'd4, 6'd11, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_fffd}, // R4
        {4'd3, 6'd12, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_000f}, // R3
        {4'd3, 6'd13, 64'h0000_0000_0000_0035, 64'h0000_0000_0000_0005}, // R3
        {4'd3, 6'd14, 64'h0000_0000_0000_00ff, 64'h0000_0000_0000_001f}, // R3
        {4'd3, 6'd15, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_0018}, // R3
        {4'd3, 6'd16, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0007_fff0}, // R3
        {4'd3, 6'd17, 64'hffff_ffff_ffff_ffff, 64'h0000_00ff_ffff_0300}, // R3
        {4'd3, 6'd18, 64'h1234_5678_9abc_def0, 64'h1234_5678_8000_0000}, // R3
        {4'd3, 6'd19, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_c000_0000}, // R3
        {4'd3, 6'd20, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_1ffb}, // R3
        {4'd3, 6'd21, 64'h0000_0000_0000_01c5, 64'h0000_0000_0000_0005}, // R3
        {4'd3, 6'd22, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_003f}, // R3
        {4'd3, 6'd23, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_07f0}, // R3
        {4'd3, 6'd24, 64'hffff_ffff_ffff_ffff, 64'hfe00_0000_0000_0000}, // R3
        {4'd2, 6'd0,  64'h5a5a_0000_ffff_1234, 64'h5a5a_0000_ffff_1234}  // R2
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_en = 0; wr_en = 0; spec = 0;
        exc_sum_set = '0; exc_mask_set = '0;
    endtask

    // drive at negedge; the write lands on the following posedge
    task automatic do_write(input logic [5:0] idx, input logic [63:0] d);
        @(negedge clk);
        idle();
        wr_en = 1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_read(input logic [5:0] idx, output logic [63:0] d, output logic f);
        rd_en = 1; rd_idx = idx;
        #1;
        d = rd_data; f = rd_fault;
        rd_en = 0;
    endtask

    initial begin
        logic [63:0] d, d2;
        logic f;
        idle();
        wr_idx = '0; wr_data = '0; rd_idx = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset values
        do_read(6'd9, d, f);  check("R1 memctl", d, 64'h6);
        do_read(6'd8, d, f);  check("R1 base", d, T_BASE);
        do_read(6'd7, d, f);  check("R1 cpu id", d, T_CPU);
        do_read(6'd0, d, f);  check("R1 scratch0", d, 64'h0);
        do_read(6'd17, d, f); check("R1 ctlstat", d, 64'h0);

        // vector table: write then read back
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][133:128], VEC[i][127:64]);
            do_read(VEC[i][133:128], d, f);
            checks++;
            if (d !== VEC[i][63:0] || f !== 1'b0) begin
                errors++;
                $display("FAIL R%0d idx %0d: actual %h expected %h",
                         VEC[i][137:134], VEC[i][133:128], d, VEC[i][63:0]);
            end
        end

        // R2 same-cycle read before the edge shows the old value
        @(negedge clk);
        wr_en = 1; wr_idx = 6'd2; wr_data = 64'h1111;
        do_read(6'd2, d, f); check("R2 pre-edge", d, 64'h0);
        @(negedge clk); wr_en = 0;
        do_read(6'd2, d, f); check("R2 post-edge", d, 64'h1111);

        // R5 sticky set and clear-on-write
        @(negedge clk); exc_sum_set = 64'ha5; exc_mask_set = 64'h30;
        @(negedge clk); exc_sum_set = '0; exc_mask_set = '0;
        do_read(6'd26, d, f); check("R5 sum set", d, 64'ha5);
        do_read(6'd27, d, f); check("R5 mask set", d, 64'h30);
        do_write(6'd26, 64'hffff_ffff_ffff_ffff);
        do_read(6'd26, d, f); check("R5 sum cleared", d, 64'h0);
        @(negedge clk); wr_en = 1; wr_idx = 6'd27; wr_data = 64'h7; exc_mask_set = 64'h4;
        @(negedge clk); idle();
        do_read(6'd27, d, f); check("R5 clear beats set", d, 64'h0);

        // R6 read-only
        @(negedge clk); wr_en = 1; wr_idx = 6'd28; wr_data = 64'h55; #1;
        check("R6 wr_fault", {63'h0, wr_fault}, 64'h1);
        @(negedge clk); wr_en = 0;
        do_read(6'd28, d, f); check("R6 value kept", d, 64'h0);
        check("R6 readable", {63'h0, f}, 64'h0);

        // R7 write-only
        do_read(6'd40, d, f); check("R7 rd_fault", {63'h0, f}, 64'h1);
        check("R7 data zero", d, 64'h0);
        do_read(6'd34, d, f); check("R7 rd_fault serial", {63'h0, f}, 64'h1);
        @(negedge clk); wr_en = 1; wr_idx = 6'd33; wr_data = 64'h1; #1;
        check("R7 write accepted", {63'h0, wr_fault}, 64'h0);
        @(negedge clk); wr_en = 0;

        // R8 unmapped
        do_read(6'd50, d, f); check("R8 rd fault", {63'h0, f}, 64'h1);
        do_read(6'd63, d, f); check("R8 rd fault top", {63'h0, f}, 64'h1);
        @(negedge clk); wr_en = 1; wr_idx = 6'd42; #1;
        check("R8 wr fault", {63'h0, wr_fault}, 64'h1);
        @(negedge clk); wr_en = 0;

        // R9 cycle register
        do_write(6'd25, 64'haaaa_bbbb_1111_2222);
        do_read(6'd25, d, f); check("R9 upper", {32'h0, d[63:32]}, 64'haaaabbbb);
        repeat (5) @(negedge clk);
        do_read(6'd25, d2, f);
        check("R9 advance", {32'h0, d2[31:0] - d[31:0]}, 64'd5);

        // R10 speculation
        @(negedge clk); spec = 1; wr_en = 1; wr_idx = 6'd1; wr_data = 64'h77; #1;
        check("R10 no fault", {63'h0, wr_fault}, 64'h0);
        @(negedge clk); wr_idx = 6'd29; #1;
        check("R10 no ro fault", {63'h0, wr_fault}, 64'h0);
        @(negedge clk); wr_idx = 6'd38;
        @(negedge clk); idle(); #1;
        check("R10 no strobe", {60'h0, inval_pulse}, 64'h0);
        do_read(6'd1, d, f); check("R10 dropped", d, 64'h0);

        // R11 invalidate strobe
        @(negedge clk); wr_en = 1; wr_idx = 6'd39;
        @(negedge clk); wr_en = 0; #1;
        check("R11 strobe", {60'h0, inval_pulse}, 64'h2);
        @(negedge clk); #1;
        check("R11 one cycle", {60'h0, inval_pulse}, 64'h0);
        @(negedge clk); wr_en = 1; wr_idx = 6'd41;
        @(negedge clk); wr_en = 0; #1;
        check("R11 strobe itb", {60'h0, inval_pulse}, 64'h8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule